// File: doc/BRIEF.md
# Column-Scan Display Controller with Per-Row Gray-Scale PWM

This block drives an emissive pixel matrix that keeps no memory in its pixels. It lights one column at a time and modulates every row in parallel. A pixel emits only while its row line and its column line are both high. The block steps through the columns in order, and each column is lit for a fixed dwell window. Within that window, each row line is pulse-width modulated from an 8-bit gray value. The window is split into 256 equal slots, so the PWM period is exactly one dwell window. A row line is high while the slot index is below that row's gray value.

Gray values come from an external frame buffer through a simple read port. The data returns one clock after the address. During each window, the block fetches the values for the column to be shown next into a shadow bank. At the window boundary it copies the shadow bank into the active bank, in the same cycle that the column select moves on. A prescaler sets the slot length in system-clock cycles, and this sets the frame rate. For example, 102 cycles at 200 MHz gives about 510 ns per slot, which is roughly 60 Hz for 128 columns.

When scanning starts, after reset or after the display is enabled, the first window is a dark priming window. It only fills the shadow bank. Column 0 is then shown first.

Top module: `colscan_pwm_ctrl`

## Requirements
- R1: While `rst` is high or `disp_en` is low, `col_sel`, `row_drv`, `frame_start` and `fb_rd_en` are all 0. Scanning restarts from the priming window on the first cycle in which both `rst` is low and `disp_en` is high.
- R2: The slot index advances by one every PRESCALE clock cycles. A dwell window is 256 slots, which is 256×PRESCALE cycles, and the next window follows with no gap.
- R3: `col_sel` is all zero in the priming window. After that it is one-hot (bit i selects column i) and steps 0, 1, …, NUM_COLS−1 and back to 0, moving on at each window boundary.
- R4: `frame_start` is high for exactly the first cycle of each window in which column 0 is selected.
- R5: In the first NUM_ROWS cycles of every window, `fb_rd_en` is high, `fb_rd_row` counts 0 to NUM_ROWS−1, and `fb_rd_col` names the column that will be shown in the next window. `fb_rd_data` is taken one cycle after its address.
- R6: Within a shown window, row r is high in every cycle whose slot index s satisfies s < G, where G is the fetched gray value. A value of 0 keeps the row dark, and 255 lights it for 255 of the 256 slots.
- R7: The values fetched during a window take effect only from the first cycle of the next window, which is the same cycle in which `col_sel` moves on.
- R8: All NUM_ROWS rows are modulated at the same time, each from its own gray value for the shown column. The design requires NUM_ROWS + 2 ≤ 256×PRESCALE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Display enable; low blanks the outputs and restarts the scan |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_rd_col | output | COL_W | Column index of the read |
| fb_rd_row | output | ROW_W | Row index of the read |
| fb_rd_data | input | 8 | Gray value, returned one cycle after the address |
| col_sel | output | NUM_COLS | One-hot active-high column select |
| row_drv | output | NUM_ROWS | Per-row PWM drive |
| frame_start | output | 1 | One-cycle pulse when column 0 becomes active |

## Verification
The embedded properties check the following on every cycle:
- the column select is at most one-hot;
- a blank column select implies dark rows;
- the frame strobe only coincides with column 0;
- the slot index only steps on a prescaler tick;
- the column only advances at a window boundary;
- reads are finished before the boundary;
- no row line rises after slot 0 of a window.

Other behaviour can only be shown by the bench's scenarios, which run a cycle-accurate model against the design:
- the exact pulse width for each gray value, including 0, 1 and 255;
- that the row data matches the shown column;
- that the priming window is dark;
- that the scan restarts correctly after a mid-window disable or reset.

// File: rtl/colscan_pkg.sv
package colscan_pkg;

    localparam int GRAY_W     = 8;
    localparam int SLOT_COUNT = 1 << GRAY_W;

    typedef logic [GRAY_W-1:0] gray_t;

    typedef struct packed {
        logic  win_end;
        gray_t slot;
    } slot_stat_t;

    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer
    import colscan_pkg::*;
#(
    parameter int PRESCALE = 102
) (
    input  logic       clk,
    input  logic       clr,
    output slot_stat_t stat
);
    localparam int PRE_W = idx_w(PRESCALE);

    logic  tick;
    gray_t slot_q;

    generate
        if (PRESCALE == 1) begin : g_no_pre
            assign tick = 1'b1;
        end else begin : g_pre
            logic [PRE_W-1:0] pre_q;
            assign tick = (pre_q == PRE_W'(PRESCALE - 1));
            always_ff @(posedge clk) begin
                if (clr)       pre_q <= '0;
                else if (tick) pre_q <= '0;
                else           pre_q <= pre_q + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr)       slot_q <= '0;
        else if (tick) slot_q <= slot_q + 1'b1;
    end

    assign stat.slot    = slot_q;
    assign stat.win_end = tick && (slot_q == gray_t'(SLOT_COUNT - 1));

    // R2: the slot index only moves by +1, and only after a tick or a clear
    p_slot_step_r2: assert property (@(posedge clk) disable iff (clr)
        (slot_q != $past(slot_q)) |-> ((slot_q == $past(slot_q) + 1'b1) && ($past(tick) || $past(clr))));

endmodule

// File: rtl/col_sequencer.sv
module col_sequencer
    import colscan_pkg::*;
#(
    parameter int NUM_COLS = 128,
    localparam int COL_W = idx_w(NUM_COLS)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             win_end,
    output logic [COL_W-1:0] fetch_col,
    output logic [COL_W-1:0] show_col,
    output logic             show_vld,
    output logic             frame_start
);
    function automatic logic [COL_W-1:0] col_next(input logic [COL_W-1:0] c);
        return (c == COL_W'(NUM_COLS - 1)) ? '0 : c + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (clr) begin
            fetch_col   <= '0;
            show_col    <= '0;
            show_vld    <= 1'b0;
            frame_start <= 1'b0;
        end else if (win_end) begin
            show_col    <= fetch_col;
            show_vld    <= 1'b1;
            fetch_col   <= col_next(fetch_col);
            frame_start <= (fetch_col == '0);
        end else begin
            frame_start <= 1'b0;
        end
    end

    // R3: the shown column steps by one (with wrap) at each boundary once valid
    p_col_advance_r3: assert property (@(posedge clk) disable iff (clr)
        (win_end && show_vld) |=> (show_col == col_next($past(show_col))));

    // R3: the shown column holds between boundaries
    p_col_hold_r3: assert property (@(posedge clk) disable iff (clr)
        (!win_end) |=> $stable(show_col));

endmodule

// File: rtl/row_fetch.sv
module row_fetch
    import colscan_pkg::*;
#(
    parameter int NUM_ROWS = 96,
    localparam int ROW_W = idx_w(NUM_ROWS),
    localparam int CNT_W = $clog2(NUM_ROWS + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             win_end,
    output logic             rd_en,
    output logic [ROW_W-1:0] rd_row,
    input  gray_t            rd_data,
    output gray_t            bank [NUM_ROWS]
);
    logic [CNT_W-1:0] fetch_row;
    logic             cap_vld;
    logic [ROW_W-1:0] cap_row;
    gray_t            shadow [NUM_ROWS];
    gray_t            active [NUM_ROWS];

    assign rd_en  = (fetch_row < CNT_W'(NUM_ROWS));
    assign rd_row = fetch_row[ROW_W-1:0];

    always_ff @(posedge clk) begin
        if (clr || win_end) fetch_row <= '0;
        else if (rd_en)     fetch_row <= fetch_row + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cap_vld <= 1'b0;
            cap_row <= '0;
        end else begin
            cap_vld <= rd_en;
            cap_row <= rd_row;
        end
    end

    always_ff @(posedge clk) begin
        if (cap_vld) shadow[cap_row] <= rd_data;
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (clr)          active[r] <= '0;
            else if (win_end) active[r] <= shadow[r];
        end
    end

    assign bank = active;

    // R5: every read of a window is finished before the boundary
    p_fetch_done_r5: assert property (@(posedge clk) disable iff (clr)
        win_end |-> (!rd_en && !cap_vld));

endmodule

// File: rtl/row_pwm_bank.sv
module row_pwm_bank
    import colscan_pkg::*;
#(
    parameter int NUM_ROWS = 96
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                en,
    input  gray_t               slot,
    input  gray_t               bank [NUM_ROWS],
    output logic [NUM_ROWS-1:0] row_drv
);
    generate
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            assign row_drv[r] = en && (slot < bank[r]);

            // R6: a row may only turn on in slot 0; later in the window it can only stay on or turn off
            p_no_midrise_r6: assert property (@(posedge clk) disable iff (clr)
                (row_drv[r] && (slot != '0)) |-> $past(row_drv[r]));
        end
    endgenerate

endmodule

// File: rtl/colscan_pwm_ctrl.sv
module colscan_pwm_ctrl
    import colscan_pkg::*;
#(
    parameter int NUM_COLS = 128,
    parameter int NUM_ROWS = 96,
    parameter int PRESCALE = 102,
    localparam int COL_W = idx_w(NUM_COLS),
    localparam int ROW_W = idx_w(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                disp_en,
    output logic                fb_rd_en,
    output logic [COL_W-1:0]    fb_rd_col,
    output logic [ROW_W-1:0]    fb_rd_row,
    input  logic [GRAY_W-1:0]   fb_rd_data,
    output logic [NUM_COLS-1:0] col_sel,
    output logic [NUM_ROWS-1:0] row_drv,
    output logic                frame_start
);
    logic             clr;
    slot_stat_t       st;
    logic [COL_W-1:0] fetch_col;
    logic [COL_W-1:0] show_col;
    logic             show_vld;
    logic             fs_q;
    logic             rd_en_i;
    logic [ROW_W-1:0] rd_row_i;
    gray_t            bank [NUM_ROWS];

    assign clr = rst || !disp_en;

    slot_timer #(.PRESCALE(PRESCALE)) u_timer (
        .clk  (clk),
        .clr  (clr),
        .stat (st)
    );

    col_sequencer #(.NUM_COLS(NUM_COLS)) u_seq (
        .clk         (clk),
        .clr         (clr),
        .win_end     (st.win_end),
        .fetch_col   (fetch_col),
        .show_col    (show_col),
        .show_vld    (show_vld),
        .frame_start (fs_q)
    );

    row_fetch #(.NUM_ROWS(NUM_ROWS)) u_fetch (
        .clk     (clk),
        .clr     (clr),
        .win_end (st.win_end),
        .rd_en   (rd_en_i),
        .rd_row  (rd_row_i),
        .rd_data (fb_rd_data),
        .bank    (bank)
    );

    row_pwm_bank #(.NUM_ROWS(NUM_ROWS)) u_pwm (
        .clk     (clk),
        .clr     (clr),
        .en      (show_vld && !clr),
        .slot    (st.slot),
        .bank    (bank),
        .row_drv (row_drv)
    );

    generate
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            assign col_sel[c] = !clr && show_vld && (show_col == COL_W'(c));
        end
    endgenerate

    assign fb_rd_en    = rd_en_i && !clr;
    assign fb_rd_row   = rd_row_i;
    assign fb_rd_col   = fetch_col;
    assign frame_start = fs_q && !clr;

    // R3: never more than one column lit
    p_col_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_sel));

    // R3: rows are dark whenever no column is selected
    p_dark_no_col_r3: assert property (@(posedge clk) disable iff (rst)
        (col_sel == '0) |-> (row_drv == '0));

    // R4: the frame strobe only coincides with column 0
    p_frame_col0_r4: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> col_sel[0]);

    // R1: disabled display drives nothing
    p_blank_off_r1: assert property (@(posedge clk) disable iff (rst)
        !disp_en |-> (col_sel == '0 && row_drv == '0 && !frame_start && !fb_rd_en));

endmodule

// File: tb/colscan_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module colscan_pwm_ctrl_tb_top;
    localparam int NC  = 4;
    localparam int NR  = 6;
    localparam int P   = 2;
    localparam int WIN = 256 * P;
    localparam int CW  = 2;
    localparam int RW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          disp_en = 1'b0;
    logic          fb_rd_en;
    logic [CW-1:0] fb_rd_col;
    logic [RW-1:0] fb_rd_row;
    logic [7:0]    fb_rd_data = '0;
    logic [NC-1:0] col_sel;
    logic [NR-1:0] row_drv;
    logic          frame_start;

    int n_tests = 0;
    int n_fail  = 0;
    int seed    = 0;
    int mcyc    = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    colscan_pwm_ctrl #(.NUM_COLS(NC), .NUM_ROWS(NR), .PRESCALE(P)) dut_i (
        .clk(clk), .rst(rst), .disp_en(disp_en),
        .fb_rd_en(fb_rd_en), .fb_rd_col(fb_rd_col), .fb_rd_row(fb_rd_row),
        .fb_rd_data(fb_rd_data), .col_sel(col_sel), .row_drv(row_drv),
        .frame_start(frame_start)
    );

    // Frame-buffer content: rows 0/1/2 hold the corner values 0, 255 and small values
    function automatic int pix(input int r, input int c, input int s);
        if (r == 0) return 0;
        if (r == 1) return 255;
        if (r == 2) return c + s;
        return (r * 41 + c * 67 + s * 29 + 3) % 256;
    endfunction

    // Memory model with one-cycle read latency
    always @(posedge clk) begin
        if (fb_rd_en) fb_rd_data <= 8'(pix(int'(fb_rd_row), int'(fb_rd_col), seed));
    end

    // Model time base: enabled cycles since the last clear
    always @(posedge clk) begin
        if (rst || !disp_en) mcyc <= 0;
        else                 mcyc <= mcyc + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at t=%0t: actual=%h expected=%h", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            automatic bit run  = !rst && disp_en;
            automatic int w    = mcyc / WIN;
            automatic int o    = mcyc % WIN;
            automatic int sl   = o / P;
            automatic int scol = (w >= 1) ? (w - 1) % NC : 0;
            automatic logic [31:0] e_col = '0;
            automatic logic [31:0] e_row = '0;
            automatic logic        e_fs  = 1'b0;
            automatic logic        e_rd  = 1'b0;
            if (!run) begin
                // R1: blanked outputs during reset or disable
                chk("R1", "blank outputs", {22'd0, col_sel, row_drv, frame_start, fb_rd_en}, 32'd0);
            end else begin
                if (w >= 1) begin
                    e_col = 32'(1) << scol;
                    for (int r = 0; r < NR; r++)
                        e_row[r] = (sl < pix(r, scol, seed));
                    e_fs = (o == 0) && (scol == 0);
                end
                e_rd = (o < NR);
                chk("R3/R7", "col_sel", 32'(col_sel), e_col);
                chk("R2/R6/R8", "row_drv", 32'(row_drv), e_row);
                chk("R4", "frame_start", 32'(frame_start), 32'(e_fs));
                chk("R5", "fb_rd_en", 32'(fb_rd_en), 32'(e_rd));
                if (e_rd) begin
                    chk("R5", "fb_rd_row", 32'(fb_rd_row), 32'(o));
                    chk("R5", "fb_rd_col", 32'(fb_rd_col), 32'(w % NC));
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        disp_en = 1'b1;
        step(4);                    // R1: reset state
        rst = 1'b0;
        step(3 * NC * WIN + 300);   // R2..R8: priming plus three full frames
        disp_en = 1'b0;             // R1: disable mid-window
        step(10);
        seed = 1;
        disp_en = 1'b1;
        step(WIN + 700);
        rst = 1'b1;                 // R1: reset mid-window
        seed = 2;
        step(3);
        rst = 1'b0;
        step(2 * NC * WIN + 100);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule